// File: doc/BRIEF.md
# Loop Branch Direction Predictor

This block predicts the direction of conditional branches that behave like loop-closing branches: a branch that resolves the same way a fixed number of times in a row and then resolves the other way exactly once. A direct-mapped table, indexed by low branch-address bits and tagged with the rest, learns for each such branch its dominant direction and its exact trip count. Once the same trip count has been seen on enough consecutive loop instances, the entry predicts the dominant direction on every iteration and the exit direction on exactly the iteration where the running count reaches the learned limit.

The lookup side is purely combinational from the stored table. It returns a hit flag, a direction and the entry's confidence. When the entry is absent or not yet confident, the block passes a fallback direction supplied by a surrounding predictor straight through, so a chooser can be built around it. The update side takes the resolved branch address and outcome, and its effect is visible to lookups after the next rising clock edge.

Top module: `loop_pred`

## Requirements
- R1: After synchronous reset every entry is empty: for any lookup address the hit flag is 0, the confidence output is 0 and the prediction equals the fallback input.
- R2: When the hit flag is 0 the prediction output equals the fallback input.
- R3: An update whose address maps to an entry holding a different tag, or an empty entry, replaces that entry. The new entry takes the update's outcome as its dominant direction, has a running count of 1, a limit of 0 and a confidence of 0. A lookup of the evicted address then reports confidence 0 and no hit.
- R4: An update in the dominant direction on a matching entry increments its running count by one.
- R5: An update opposite to the dominant direction (an exit) clears the running count. If the count equalled the learned limit, the 2-bit confidence increments and saturates at 3; otherwise the limit takes the count and confidence returns to 0. Confidence never rises by more than one per update.
- R6: The hit flag is 1 only when the address tag matches a valid entry whose confidence is 3; the confidence output is the entry's confidence on a tag match and 0 otherwise.
- R7: On a hit the prediction is the exit direction when the running count equals the limit, and the dominant direction otherwise. For a loop with a stable trip count N (N dominant outcomes, then one exit), taken-dominant or not-taken-dominant, every iteration from the fifth loop instance onward is predicted correctly.
- R8: A dominant-direction update on an entry whose running count is already 255 invalidates the entry (hit 0, confidence 0 afterwards).
- R9: Lookup outputs depend only on the stored table and the lookup inputs. An update changes them only after the next rising clock edge, and without updates they stay constant.
- R10: When a confident loop's trip count changes, the entry mispredicts the exit at the old count, relearns the new count on the next exit with confidence 0, and becomes confident again after three more loop instances with the new count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | ADDR_W | Branch address to predict |
| lk_fallback | input | 1 | Direction from the surrounding predictor, used when there is no hit |
| lk_hit | output | 1 | Entry matches and is fully confident |
| lk_pred | output | 1 | Predicted direction, 1 = taken |
| lk_conf | output | 2 | Confidence of the matching entry, 0 on a miss |
| up_en | input | 1 | Resolved-branch update strobe |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench sweeps trip counts from 1 to 12 in both dominant directions and checks hit, direction and confidence before every single update. A design that predicts the exit one iteration early or late, counts the allocating outcome wrongly, or lets confidence become usable after the wrong number of instances is caught on the first loop where that matters. Separate scenarios force an eviction by a second address at the same index, a change of trip count on a confident loop (the exit is mispredicted once and confidence must drop to 0), and a dominant run long enough to overflow the 8-bit count. A design that saturated instead of invalidating, or that kept a stale entry's confidence after aliasing, would keep reporting a hit where none is expected.

// File: rtl/loop_pred_pkg.sv
package loop_pred_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned CONF_W = 2;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [CONF_W-1:0] conf_t;

  localparam cnt_t  CNT_MAX  = '1;
  localparam conf_t CONF_MAX = '1;

  typedef struct packed {
    logic  dir;    // dominant direction, 1 = taken
    cnt_t  count;  // dominant outcomes seen in the current instance
    cnt_t  limit;  // learned trip count
    conf_t conf;   // consecutive exits at the learned limit
  } lp_state_t;
endpackage

// File: rtl/loop_pred_addr.sv
module loop_pred_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [ADDR_W-1:0]       pc,
  output logic [IDX_W-1:0]        idx,
  output logic [ADDR_W-IDX_W-1:0] tag
);
  assign idx = pc[IDX_W-1:0];
  assign tag = pc[ADDR_W-1:IDX_W];
endmodule

// File: rtl/loop_pred_predict.sv
module loop_pred_predict
  import loop_pred_pkg::*;
(
  input  lp_state_t st,
  input  logic      match,
  input  logic      fallback,
  output logic      hit,
  output logic      pred,
  output conf_t     conf
);
  logic at_exit;

  assign at_exit = (st.count == st.limit);
  assign hit     = match && (st.conf == CONF_MAX);
  assign pred    = hit ? (at_exit ? ~st.dir : st.dir) : fallback;
  assign conf    = match ? st.conf : '0;
endmodule

// File: rtl/loop_pred_train.sv
module loop_pred_train
  import loop_pred_pkg::*;
(
  input  lp_state_t cur,
  input  logic      match,
  input  logic      taken,
  output lp_state_t nxt,
  output logic      nxt_valid
);
  always_comb begin
    nxt       = cur;
    nxt_valid = 1'b1;
    if (!match) begin
      nxt.dir   = taken;
      nxt.count = cnt_t'(1);
      nxt.limit = '0;
      nxt.conf  = '0;
    end else if (taken == cur.dir) begin
      if (cur.count == CNT_MAX) begin
        nxt_valid = 1'b0;
      end else begin
        nxt.count = cur.count + cnt_t'(1);
      end
    end else begin
      nxt.count = '0;
      if (cur.count == cur.limit) begin
        if (cur.conf != CONF_MAX) nxt.conf = cur.conf + conf_t'(1);
      end else begin
        nxt.limit = cur.count;
        nxt.conf  = '0;
      end
    end
  end
endmodule

// File: rtl/loop_pred.sv
module loop_pred
  import loop_pred_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              lk_fallback,
  output logic              lk_hit,
  output logic              lk_pred,
  output logic [1:0]        lk_conf,
  input  logic              up_en,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  lp_state_t          st_mem  [ENTRIES];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             lk_match, up_match, up_nvalid;
  lp_state_t        up_next;
  conf_t            lk_conf_w;

  loop_pred_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_addr (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag));
  loop_pred_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_up_addr (
    .pc(up_pc), .idx(up_idx), .tag(up_tag));

  assign lk_match = vld_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign up_match = vld_q[up_idx] && (tag_mem[up_idx] == up_tag);

  loop_pred_predict u_predict (
    .st(st_mem[lk_idx]), .match(lk_match), .fallback(lk_fallback),
    .hit(lk_hit), .pred(lk_pred), .conf(lk_conf_w));
  assign lk_conf = lk_conf_w;

  loop_pred_train u_train (
    .cur(st_mem[up_idx]), .match(up_match), .taken(up_taken),
    .nxt(up_next), .nxt_valid(up_nvalid));

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (up_en) vld_q[up_idx] <= up_nvalid;
  end

  always_ff @(posedge clk) begin
    if (up_en) begin
      tag_mem[up_idx] <= up_tag;
      st_mem[up_idx]  <= up_next;
    end
  end
endmodule

// File: rtl/loop_pred_chk.sv
module loop_pred_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              lk_fallback,
  input logic              lk_hit,
  input logic              lk_pred,
  input logic [1:0]        lk_conf,
  input logic              up_en
);
  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!lk_hit && lk_conf == 2'd0));

  // R2
  fallback_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_pred == lk_fallback));

  // R6
  hit_needs_conf_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_conf == 2'd3));

  // R5
  conf_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(lk_pc) && (lk_conf > $past(lk_conf)))
      |-> (lk_conf == 2'($past(lk_conf) + 2'd1)));

  // R9
  table_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(up_en) && $stable(lk_pc)) |-> ($stable(lk_conf) && $stable(lk_hit)));
endmodule

bind loop_pred loop_pred_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_fallback(lk_fallback),
  .lk_hit(lk_hit), .lk_pred(lk_pred), .lk_conf(lk_conf), .up_en(up_en));

// File: tb/loop_pred_bench.sv
module loop_pred_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        lk_fallback = 1'b0;
  logic        lk_hit, lk_pred;
  logic [1:0]  lk_conf;
  logic        up_en = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  loop_pred u_loop_pred (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_fallback(lk_fallback),
    .lk_hit(lk_hit), .lk_pred(lk_pred), .lk_conf(lk_conf),
    .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken));

  task automatic look(input logic [31:0] pc, input logic fb, input logic eh,
                      input logic ep, input logic [1:0] ec, input string rq);
    @(negedge clk);
    up_en = 1'b0;
    lk_pc = pc;
    lk_fallback = fb;
    #1;
    checks++;
    if (lk_hit !== eh || lk_pred !== ep || lk_conf !== ec) begin
      fails++;
      $display("FAIL %s pc=%h hit %b exp %b pred %b exp %b conf %0d exp %0d",
               rq, pc, lk_hit, eh, lk_pred, ep, lk_conf, ec);
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic t);
    up_en = 1'b1;
    up_pc = pc;
    up_taken = t;
    @(posedge clk);
    #1;
    up_en = 1'b0;
  endtask

  // Stable loop: n dominant outcomes then one exit, repeated inst times on a fresh entry.
  task automatic run_loop(input logic [31:0] pc, input logic dir, input int n,
                          input int inst);
    for (int i = 0; i < inst; i++) begin
      for (int k = 0; k <= n; k++) begin
        logic fb, eh, ep;
        logic [1:0] ec;
        fb = 1'(k + i) ^ dir;
        ec = (i == 0) ? 2'd0 : ((i - 1 > 3) ? 2'd3 : 2'(i - 1));
        eh = (i >= 4);
        ep = eh ? ((k == n) ? ~dir : dir) : fb;
        look(pc, fb, eh, ep, ec, eh ? "R7" : "R5");
        upd(pc, (k == n) ? ~dir : dir);
      end
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int ns[6] = '{1, 2, 3, 4, 7, 12};
    logic [31:0] pa, pb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: empty table after reset, fallback passes through
    for (int j = 0; j < 16; j++) begin
      look(32'h1000 + 32'(j), 1'(j), 1'b0, 1'(j), 2'd0, "R1");
    end

    // R4 R5 R6 R7: sweep trip counts in both dominant directions
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 6; s++) begin
        int j;
        j = d * 6 + s;
        run_loop(32'((j + 1) << 8) | 32'(j), 1'(d), ns[s], 6);
      end
    end

    // R3: alias at index 13 evicts a confident entry
    pa = 32'h0000_AB0D;
    pb = 32'h0000_CD0D;
    run_loop(pa, 1'b1, 3, 5);
    look(pa, 1'b0, 1'b1, 1'b1, 2'd3, "R6");
    upd(pb, 1'b0);
    look(pa, 1'b0, 1'b0, 1'b0, 2'd0, "R3");
    look(pa, 1'b1, 1'b0, 1'b1, 2'd0, "R2");
    look(pb, 1'b1, 1'b0, 1'b1, 2'd0, "R3");
    upd(pa, 1'b1);
    look(pb, 1'b0, 1'b0, 1'b0, 2'd0, "R3");

    // R10: trip count changes from 3 to 5 at index 14
    pa = 32'h0000_770E;
    run_loop(pa, 1'b1, 3, 6);
    for (int k = 0; k <= 5; k++) begin
      look(pa, 1'b0, 1'b1, (k == 3) ? 1'b0 : 1'b1, 2'd3, "R10");
      upd(pa, (k == 5) ? 1'b0 : 1'b1);
    end
    look(pa, 1'b1, 1'b0, 1'b1, 2'd0, "R10");
    for (int i = 0; i < 3; i++) begin
      for (int k = 0; k <= 5; k++) upd(pa, (k == 5) ? 1'b0 : 1'b1);
      look(pa, 1'b0, (i == 2), (i == 2), 2'(i + 1), "R10");
    end
    for (int k = 0; k <= 5; k++) begin
      look(pa, 1'b1, 1'b1, (k == 5) ? 1'b0 : 1'b1, 2'd3, "R10");
      upd(pa, (k == 5) ? 1'b0 : 1'b1);
    end

    // R9: update becomes visible only after the edge
    pa = 32'h0000_550F;
    @(negedge clk);
    lk_pc = pa;
    lk_fallback = 1'b1;
    up_en = 1'b1;
    up_pc = pa;
    up_taken = 1'b0;
    #1;
    checks++;
    if (lk_hit !== 1'b0 || lk_pred !== 1'b1 || lk_conf !== 2'd0) begin
      fails++;
      $display("FAIL R9 hit %b exp 0 pred %b exp 1 conf %0d exp 0", lk_hit, lk_pred, lk_conf);
    end
    @(posedge clk);
    #1;
    up_en = 1'b0;

    // R8: overflow of the running count at index 15, not-taken dominant
    pa = 32'h0000_990F;
    run_loop(pa, 1'b0, 2, 6);
    for (int k = 0; k < 255; k++) upd(pa, 1'b0);
    look(pa, 1'b1, 1'b1, 1'b0, 2'd3, "R8");
    upd(pa, 1'b0);
    look(pa, 1'b1, 1'b0, 1'b1, 2'd0, "R8");
    look(pa, 1'b0, 1'b0, 1'b0, 2'd0, "R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule